// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Resolver

This block answers interrupt acknowledge reads for a prioritised interrupt controller. Each of `NSRC` sources arrives with a pending flag, a mask bit, a 3-bit level and a 3-bit priority. A byte-wide read strobe selects one of eight read-only acknowledge registers. Seven of them are level-specific: each searches one level for its best pending source. The eighth is a software acknowledge: it searches every level for the best pending source.

Every read registers two results. The first is an 8-bit vector for the winning source. The second is a capture byte holding that source's level and priority. An interrupt service routine can use the software acknowledge near its exit to find any further pending work. It can then branch straight to that handler without taking a new exception.

When nothing qualifies, both results read as zero. Reading never clears a source. Sources clear only through their own flag logic, outside this block.

Top module: `irq_ack_resolver`

## Requirements
- R1: After reset, `ack_vec` and `lp_cap` are both 0x00.
- R2: `ack_sel` value 0 selects the software acknowledge, and values 1..7 select the acknowledge for that level. A winning source k returns vector `VBASE + k` in bits 7..0 of `ack_vec`, with `VBASE` = 64 by default.
- R3: A level-m read (`ack_sel` = m) returns the vector of the eligible source at level m with the highest priority.
- R4: A software read returns the vector of the eligible source with the highest level, taking the highest priority within that level.
- R5: When several eligible sources share the best level and priority, the lowest-numbered source wins.
- R6: A source is eligible only when its pending bit is 1, its mask bit is 0 and its level is non-zero. Masked sources and level-0 sources are never returned by either kind of read.
- R7: On each read, `lp_cap` takes the winner's level in bits 6..4 and its priority in bits 2..0, with bits 7 and 3 at zero. It updates on the same clock edge as `ack_vec`, one cycle after the strobe.
- R8: A read with no eligible source returns vector 0x00 and clears `lp_cap` to 0x00.
- R9: Without a read strobe, `ack_vec` and `lp_cap` keep their values whatever the sources do. A read does not consume its source, so a repeated read returns the same vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pend | input | NSRC | Pending flag per source |
| src_mask | input | NSRC | Mask bit per source (1 = masked) |
| src_level | input | 3*NSRC | Level of source k in bits 3k+2..3k (0 = disabled) |
| src_prio | input | 3*NSRC | Priority of source k in bits 3k+2..3k |
| ack_rd | input | 1 | Read strobe, one cycle per read |
| ack_sel | input | 3 | Register select: 0 software, 1..7 level |
| ack_vec | output | 8 | Registered vector of the last read |
| lp_cap | output | 8 | Level/priority capture register |

## Verification
The bench builds the block with its defaults: `NSRC` = 64 and `VBASE` = 64. With these values the top source produces vector 127 and source 0 produces vector 64, so both ends of the vector range can be reached. All seven levels and the full priority range fit within the 64 sources. That makes room for ties, masking and level-0 exclusion to be set up at the same level and priority as real winners, so each exclusion rule changes a visible result.

// File: rtl/irq_ack_resolver.sv
module irq_ack_resolver #(
  parameter int NSRC  = 64,
  parameter int VBASE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_pend,
  input  logic [NSRC-1:0]   src_mask,
  input  logic [3*NSRC-1:0] src_level,
  input  logic [3*NSRC-1:0] src_prio,
  input  logic              ack_rd,
  input  logic [2:0]        ack_sel,
  output logic [7:0]        ack_vec,
  output logic [7:0]        lp_cap
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic          hit;
  logic [IW-1:0] win_idx;
  logic [5:0]    win_key;

  // Strict compare while scanning upward keeps the lowest index on ties.
  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    win_key = '0;
    for (int k = 0; k < NSRC; k++) begin
      logic [2:0] lv;
      logic [5:0] key;
      logic       ok;
      lv  = src_level[3*k +: 3];
      key = {lv, src_prio[3*k +: 3]};
      ok  = src_pend[k] && !src_mask[k] && (lv != 3'd0) &&
            ((ack_sel == 3'd0) || (lv == ack_sel));
      if (ok && (!hit || key > win_key)) begin
        hit     = 1'b1;
        win_idx = IW'(k);
        win_key = key;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_vec <= 8'h00;
      lp_cap  <= 8'h00;
    end else if (ack_rd) begin
      ack_vec <= hit ? 8'(VBASE) + 8'(win_idx) : 8'h00;
      lp_cap  <= hit ? {1'b0, win_key[5:3], 1'b0, win_key[2:0]} : 8'h00;
    end
  end

  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !hit) |=> (ack_vec == 8'h00 && lp_cap == 8'h00));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_rd |=> ($stable(ack_vec) && $stable(lp_cap)));

  p_cap_pairs_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd |=> ((ack_vec == 8'h00) == (lp_cap == 8'h00)) && !lp_cap[7] && !lp_cap[3]);

  p_level_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && ack_sel != 3'd0) |=> (lp_cap == 8'h00 || lp_cap[6:4] == $past(ack_sel)));

  p_vec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vec == 8'h00 || (ack_vec >= 8'(VBASE) && ack_vec < 8'(VBASE + NSRC)));
endmodule

// File: tb/tb_irq_ack_resolver.sv
module tb_irq_ack_resolver;
  localparam int N = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]   pend = '0, mask = '0;
  logic [3*N-1:0] lvl = '0, pri = '0;
  logic ack_rd = 1'b0;
  logic [2:0] ack_sel = 3'd0;
  logic [7:0] ack_vec, lp_cap;

  int checks = 0, errors = 0;
  logic [7:0] q_vec[$], q_cap[$];
  string q_tag[$];

  always #10 clk = ~clk;

  irq_ack_resolver #(.NSRC(N), .VBASE(64)) dut (
    .clk(clk), .rst_n(rst_n), .src_pend(pend), .src_mask(mask),
    .src_level(lvl), .src_prio(pri), .ack_rd(ack_rd), .ack_sel(ack_sel),
    .ack_vec(ack_vec), .lp_cap(lp_cap));

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic set_src(int k, int l, int p, bit pd);
    lvl[3*k +: 3] = 3'(l);
    pri[3*k +: 3] = 3'(p);
    pend[k] = pd;
  endtask

  // Reference from the requirement text: best level (software) or the given
  // level, then best priority, then lowest index.
  task automatic expect_read(int sel, output logic [7:0] v, output logic [7:0] c);
    int bi = -1, bl = 0, bp = 0;
    for (int k = 0; k < N; k++) begin
      int l = int'(lvl[3*k +: 3]);
      int p = int'(pri[3*k +: 3]);
      if (pend[k] && !mask[k] && l != 0 && (sel == 0 || l == sel)) begin
        if (bi < 0 || l > bl || (l == bl && p > bp)) begin
          bi = k; bl = l; bp = p;
        end
      end
    end
    if (bi < 0) begin v = 8'h00; c = 8'h00; end
    else begin v = 8'(64 + bi); c = 8'((bl << 4) | bp); end
  endtask

  task automatic do_read(int sel, string tag);
    logic [7:0] v, c;
    @(negedge clk);
    ack_sel = 3'(sel);
    expect_read(sel, v, c);
    q_vec.push_back(v); q_cap.push_back(c); q_tag.push_back(tag);
    ack_rd = 1'b1;
    @(negedge clk);
    ack_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (ack_rd) begin
        @(negedge clk);
        if (q_vec.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard: result with no expectation");
        end else begin
          string t;
          logic [7:0] ev, ec;
          ev = q_vec.pop_front(); ec = q_cap.pop_front(); t = q_tag.pop_front();
          check({t, " vector"}, ack_vec, ev);
          check({t, " capture"}, lp_cap, ec);
        end
      end
    end
  end

  initial begin
    #4ms;
    checks++; errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] hv, hc;
    repeat (3) @(negedge clk);
    check("R1 reset vector", ack_vec, 8'h00);
    check("R1 reset capture", lp_cap, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    do_read(0, "R8 empty software");
    do_read(3, "R8 empty level3");

    set_src(5, 3, 2, 1);
    set_src(10, 3, 6, 1);
    set_src(20, 5, 1, 1);
    do_read(3, "R3 level3 best prio");
    do_read(0, "R4 software best level");
    do_read(5, "R3 level5");
    do_read(4, "R8 empty level4");

    set_src(30, 3, 6, 1);
    do_read(3, "R5 tie lowest index");
    mask[10] = 1'b1;
    do_read(3, "R6 masked excluded level");
    set_src(40, 0, 7, 1);
    mask[20] = 1'b1;
    do_read(0, "R6 masked and level0 excluded software");

    do_read(0, "R9 repeat read first");
    do_read(0, "R9 repeat read second");
    hv = ack_vec; hc = lp_cap;
    set_src(50, 7, 7, 1);
    pend[30] = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 idle hold vector", ack_vec, hv);
    check("R9 idle hold capture", lp_cap, hc);

    set_src(63, 7, 7, 1);
    mask[50] = 1'b1;
    do_read(0, "R2 top source vector");
    do_read(7, "R7 capture level7");

    pend = '0; mask = '0;
    set_src(0, 1, 0, 1);
    do_read(1, "R2 source0 vector");
    do_read(0, "R7 capture level1 prio0");
    pend = '0;
    do_read(0, "R8 cleared after winner");

    repeat (3) @(negedge clk);
    if (q_vec.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d results missing, expected 0", q_vec.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule